// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Transmitter

This block turns parallel words written over a simple write port into a serial bit stream, one word per frame. The serial bit clock reaches the block as a one-cycle strobe `bit_stb` in the system clock domain. A frame begins when `fsync` is high during a strobe. At that boundary the shifter takes its next word, either from a single holding register or from an 8-entry FIFO, depending on `fifo_en`. The word goes out MSB first, one bit per strobe. `sdo_oe` is high only for the selected number of bits and is low for the rest of the frame.

The block tracks word availability and reports it through empty flags and a gated interrupt request. If a frame starts and no fresh word is waiting, the block flags an underrun and sends the previous word again. Software clears the underrun flag by pulsing `clr_urun`. A write to a full FIFO is dropped and sets a sticky overflow flag. A change of `tx_en` takes effect only at a frame boundary, so no partial word is ever sent.

Top module: `fs_ser_tx`

## Requirements
- R1: After synchronous active-low reset, `sdo_oe`=0, `hold_empty`=1, `fifo_empty`=1, `fifo_full`=0, `urun`=0, `ovf`=0 and `irq`=0.
- R2: When `bit_stb`, `fsync` and `tx_en` are all high, the next word is loaded and its MSB appears on `sdo` after that clock edge. Each later strobe without `fsync` presents the next lower bit. Clocks without a strobe leave `sdo` unchanged.
- R3: `wl_sel` selects the word length: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 16. `sdo_oe` is high for exactly that many bit periods after the frame strobe and then goes low, even while strobes continue.
- R4: `sdo_oe` stays low outside the transmission period. A frame strobe with `tx_en`=0 sends nothing. Raising `tx_en` in the middle of a frame sends nothing until the next frame strobe.
- R5: With `fifo_en`=0, the word comes from the holding register. A write clears `hold_empty`. A frame load that consumes the word sets `hold_empty`.
- R6: With `fifo_en`=1, writes push into an 8-deep FIFO and frames send the words in write order. `fifo_empty` and `fifo_full` report the FIFO occupancy.
- R7: A write to a full FIFO is ignored and sets `ovf`. `ovf` stays set until reset.
- R8: A frame load that finds no new word sets `urun` and sends the previously sent word again. The no-new-word condition is `hold_empty`=1, or with the FIFO enabled `fifo_empty`=1. `urun` stays set until `clr_urun` is pulsed high.
- R9: `irq` = `tx_irq_en` AND (`fifo_empty` if `fifo_en`=1, else `hold_empty`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable, sampled at frame strobes |
| fifo_en | input | 1 | 1: words pass through the FIFO; 0: holding register only |
| wl_sel | input | 2 | Word length code (0=8, 1=10, 2=12, 3=16 bits) |
| tx_irq_en | input | 1 | Interrupt request enable |
| bit_stb | input | 1 | One-cycle strobe marking a bit clock rising edge |
| fsync | input | 1 | Frame sync, qualified by `bit_stb` |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | 16 | Word to write |
| clr_urun | input | 1 | Pulse high to clear `urun` |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| hold_empty | output | 1 | Holding register has no unsent word |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds 8 words |
| ovf | output | 1 | Sticky FIFO overflow flag |
| urun | output | 1 | Underrun flag |
| irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume that a frame strobe never arrives before the current word has finished shifting. They also assume that `wl_sel` and `fifo_en` do not change during a frame. The bench keeps within these limits. Every frame it sends is followed by at least word-length strobes, plus one more, before the next `fsync`. It changes the mode inputs only between frames, while `sdo_oe` is low.

// File: rtl/fs_ser_tx_pkg.sv
package fs_ser_tx_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  // word length in bits for a 2-bit length code
  function automatic logic [CNT_W-1:0] wl_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    wl_bits = CNT_W'(8);
      2'd1:    wl_bits = CNT_W'(10);
      2'd2:    wl_bits = CNT_W'(12);
      default: wl_bits = CNT_W'(16);
    endcase
  endfunction

  // move the low n bits of a word to the top so the MSB leaves first
  function automatic logic [WORD_W-1:0] msb_align(input logic [WORD_W-1:0] w,
                                                  input logic [CNT_W-1:0] n);
    msb_align = w << (WORD_W - n);
  endfunction
endpackage

// File: rtl/fs_tx_fifo.sv
module fs_tx_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic          drop
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign drop    = push & full;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/fs_tx_shifter.sv
module fs_tx_shifter
  import fs_ser_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              fsync,
  input  logic              tx_en,
  input  logic [1:0]        wl_sel,
  input  logic [WORD_W-1:0] load_word,
  output logic              start,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  logic              frame_edge, shift_evt;

  assign frame_edge = bit_stb & fsync;
  assign start      = frame_edge & tx_en;
  assign shift_evt  = bit_stb & ~fsync & (left != '0);
  assign sdo        = shreg[WORD_W-1];
  assign sdo_oe     = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (start) begin
      shreg <= msb_align(load_word, wl_bits(wl_sel));
      left  <= wl_bits(wl_sel);
    end else if (frame_edge) begin
      left  <= '0;
    end else if (shift_evt) begin
      shreg <= {shreg[WORD_W-2:0], 1'b0};
      left  <= left - 1'b1;
    end
  end

  p_oe_needs_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(start));
  p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_edge && !tx_en) |=> !sdo_oe);
  p_last_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && left == CNT_W'(1)) |=> !sdo_oe);
  p_hold_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb) |=> $stable(sdo));
endmodule

// File: rtl/fs_ser_tx.sv
module fs_ser_tx
  import fs_ser_tx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              fifo_en,
  input  logic [1:0]        wl_sel,
  input  logic              tx_irq_en,
  input  logic              bit_stb,
  input  logic              fsync,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              clr_urun,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              hold_empty,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              ovf,
  output logic              urun,
  output logic              irq
);
  logic [WORD_W-1:0] hold_q, last_q, fifo_dout, src_word, load_word;
  logic              start, avail, push, pop, drop;

  assign push      = wr_en & fifo_en;
  assign pop       = start & fifo_en & ~fifo_empty;
  assign avail     = fifo_en ? ~fifo_empty : ~hold_empty;
  assign src_word  = fifo_en ? fifo_dout : hold_q;
  assign load_word = avail ? src_word : last_q;
  assign irq       = tx_irq_en & (fifo_en ? fifo_empty : hold_empty);

  fs_tx_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(wr_data),
    .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full), .drop(drop)
  );

  fs_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .fsync(fsync), .tx_en(tx_en),
    .wl_sel(wl_sel), .load_word(load_word), .start(start), .sdo(sdo),
    .sdo_oe(sdo_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_empty <= 1'b1;
      last_q     <= '0;
      urun       <= 1'b0;
      ovf        <= 1'b0;
    end else begin
      if (wr_en && !fifo_en) begin
        hold_q     <= wr_data;
        hold_empty <= 1'b0;
      end else if (start && !fifo_en) begin
        hold_empty <= 1'b1;
      end
      if (start) last_q <= load_word;
      if (start && !avail) urun <= 1'b1;
      else if (clr_urun)   urun <= 1'b0;
      if (drop) ovf <= 1'b1;
    end
  end

  p_urun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !avail) |=> urun);
  p_hold_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fifo_en) |=> !hold_empty);
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tx_irq_en);
endmodule

// File: tb/fs_ser_tx_tb.sv
module fs_ser_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, fifo_en = 1'b0, tx_irq_en = 1'b0;
  logic [1:0] wl_sel = 2'd0;
  logic bit_stb = 1'b0, fsync = 1'b0, wr_en = 1'b0, clr_urun = 1'b0;
  logic [15:0] wr_data = '0;
  logic sdo, sdo_oe, hold_empty, fifo_empty, fifo_full, ovf, urun, irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fs_ser_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fifo_en(fifo_en), .wl_sel(wl_sel),
    .tx_irq_en(tx_irq_en), .bit_stb(bit_stb), .fsync(fsync), .wr_en(wr_en),
    .wr_data(wr_data), .clr_urun(clr_urun), .sdo(sdo), .sdo_oe(sdo_oe),
    .hold_empty(hold_empty), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .ovf(ovf), .urun(urun), .irq(irq)
  );

  // {length code, word}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 16'h00A5}, {2'd1, 16'h02C3}, {2'd2, 16'h0F0F},
    {2'd3, 16'h8001}, {2'd3, 16'h1234}, {2'd0, 16'h003C}
  };

  function automatic int nbits(input logic [1:0] c);
    return (c == 2'd3) ? 16 : 8 + 2 * int'(c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic stb, input logic fs);
    bit_stb = stb; fsync = fs;
    @(posedge clk); #2;
    bit_stb = 1'b0; fsync = 1'b0; wr_en = 1'b0; clr_urun = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1'b0, 1'b0);
  endtask

  task automatic frame(output logic [15:0] got, output int n);
    got = '0; n = 0;
    step(1'b1, 1'b1);
    while (sdo_oe && n < 20) begin
      got = {got[14:0], sdo};
      n++;
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
    end
    step(1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] got;
    int n;
    @(negedge clk);
    step(1'b0, 1'b0); step(1'b0, 1'b0);
    check("R1 oe", sdo_oe, 0);  check("R1 hold_empty", hold_empty, 1);
    check("R1 fifo_empty", fifo_empty, 1); check("R1 fifo_full", fifo_full, 0);
    check("R1 urun", urun, 0); check("R1 ovf", ovf, 0); check("R1 irq", irq, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);

    // R4: disabled transmitter stays quiet; mid-frame enable waits
    wr(16'h00FF);
    step(1'b1, 1'b1);
    check("R4 off at frame", sdo_oe, 0);
    tx_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0);
      check("R4 mid-frame enable", sdo_oe, 0);
    end
    check("R5 word kept", hold_empty, 0);

    // table: holding register mode, R2 R3 R5
    tx_irq_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      wl_sel = VEC[v][17:16];
      if (v > 0) begin
        check("R9 irq when hold empty", irq, 1);
        wr(VEC[v][15:0]);
        check("R9 irq cleared", irq, 0);
      end
      check("R5 hold full", hold_empty, 0);
      frame(got, n);
      check("R3 bit count", n, nbits(VEC[v][17:16]));
      check("R2 word bits", got,
            (v == 0) ? 16'h00FF : (VEC[v][15:0] & 16'((32'd1 << nbits(VEC[v][17:16])) - 1)));
      check("R5 hold empty after load", hold_empty, 1);
    end

    // R8: underrun in holding mode resends last word
    frame(got, n);
    check("R8 urun set", urun, 1);
    check("R8 resend", got, 16'h003C);
    clr_urun = 1'b1; step(1'b0, 1'b0);
    check("R8 urun cleared", urun, 0);

    // R6: FIFO order
    fifo_en = 1'b1; wl_sel = 2'd3;
    check("R9 irq fifo empty", irq, 1);
    wr(16'hA001); wr(16'hB002); wr(16'hC003);
    check("R6 not empty", fifo_empty, 0);
    check("R9 irq fifo", irq, 0);
    frame(got, n); check("R6 first", got, 16'hA001);
    frame(got, n); check("R6 second", got, 16'hB002);
    frame(got, n); check("R6 third", got, 16'hC003);
    check("R6 empty", fifo_empty, 1);
    check("R8 no urun with data", urun, 0);

    // R7: overflow
    for (int i = 0; i < 8; i++) wr(16'h0100 + 16'(i));
    check("R6 full", fifo_full, 1);
    check("R7 ovf before", ovf, 0);
    wr(16'hDEAD);
    check("R7 ovf set", ovf, 1);
    for (int i = 0; i < 8; i++) begin
      frame(got, n);
      check("R7 drained word", got, 16'h0100 + 16'(i));
    end
    check("R7 ovf sticky", ovf, 1);
    frame(got, n);
    check("R8 fifo underrun", urun, 1);
    check("R8 fifo resend", got, 16'h0107);
    check("R3 oe low after word", sdo_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule